// File: doc/BRIEF.md
# Linked Sprite Line Scanner

This block decides which sprites touch one scanline. Sprite attributes sit in video memory as a table of 8-byte entries, and each entry carries a link to the next one. On a start strobe the scanner begins at entry 0 and follows the links through a byte-wide read port with one cycle of latency. For each entry it reads the vertical position, the size byte and the link. It compares the span against the line after the requested one, held in a coordinate space shifted down by 128 pixels.

Each sprite that covers the line is written into a per-line slot list. The list fills from its top slot downward, and each record holds the raw size byte, the sprite index and the vertical position with the 128-pixel offset removed. A wide/narrow mode input sets both the number of slots and the highest sprite index the walk may visit. When the walk ends, a done flag rises and the slot list can be read back through a select port.

Top module: `sls_line_scanner`

## Requirements
- R1: After reset, busy_o and done_o are 0, vram_rd_o is 0 and free_slots_o is 0.
- R2: Each visited entry is read as exactly four bytes, offsets 0 to 3, at address (tbl_base_i * 512 + index * 8 + offset) mod 65536. One read is issued per cycle, and the data returns one cycle after the read. The walk always starts at index 0.
- R3: The entry's Y is {byte0[1:0], byte1} and its height is (byte2[1:0] + 1) * 8. The compare value is ((line_i + 1) mod 256) + 128. The sprite hits when Y <= compare < Y + height.
- R4: A scan loads free_slots_o with 20 in wide mode (wide_i = 1) or 16 in narrow mode. Each hit decrements it and is stored in slot number (new free_slots_o). A slot record holds the size byte (all 8 bits), the 7-bit index and (Y - 128) mod 1024.
- R5: The next index is byte3[6:0]. The walk ends after an entry whose link is 0.
- R6: The walk ends as soon as free_slots_o reaches 0, even when the link is non-zero.
- R7: A link at or above 80 (wide) or 64 (narrow) ends the walk, and that entry is not read.
- R8: busy_o is high from the cycle after an accepted start until the walk ends. done_o then rises and stays high until the next accepted start. A start while busy_o is high is ignored.
- R9: slot_sel_i selects a slot. slot_size_o, slot_idx_o and slot_y_o show that slot's record in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| wide_i | input | 1 | 1 = wide mode, 0 = narrow mode |
| line_i | input | 8 | Scanline number |
| tbl_base_i | input | 7 | Table base, in 512-byte units |
| vram_addr_o | output | 16 | Video memory byte address |
| vram_rd_o | output | 1 | Read request |
| vram_data_i | input | 8 | Read data, one cycle after the request |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Last walk has finished |
| free_slots_o | output | 5 | Unused slots remaining |
| slot_sel_i | input | 5 | Slot read select |
| slot_size_o | output | 8 | Selected slot size byte |
| slot_idx_o | output | 7 | Selected slot sprite index |
| slot_y_o | output | 10 | Selected slot Y minus 128 |

## Verification
The assertions assume that memory returns data exactly one cycle after each request. They also assume the link chain in memory either ends with a zero link or produces enough hits to fill the slots, because a circular chain with no hits would never terminate. The stimulus builds every table with acyclic links, either in ascending order or as explicit short chains. The modelled memory always answers on the next cycle. Inputs change only at the falling edge, and start is held for one cycle, except where a start during a walk is deliberately tested.

// File: rtl/sls_pkg.sv
package sls_pkg;

  localparam int IDX_W  = 7;
  localparam int ADDR_W = 16;
  localparam int Y_W    = 10;

  typedef struct packed {
    logic [7:0]       size;
    logic [IDX_W-1:0] idx;
    logic [Y_W-1:0]   y;
  } slot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_COMPARE, ST_LINK} scan_st_t;

  // line after the requested one, moved into the offset coordinate space
  function automatic logic [8:0] cmp_line(input logic [7:0] line);
    logic [7:0] nxt;
    nxt = line + 8'd1;
    return {1'b0, nxt} + 9'd128;
  endfunction

  // sprite height in pixels from the size byte
  function automatic logic [5:0] span_px(input logic [7:0] sz);
    return ({4'd0, sz[1:0]} + 6'd1) << 3;
  endfunction

  function automatic logic covers(input logic [Y_W-1:0] y, input logic [7:0] sz,
                                  input logic [8:0] cl);
    logic [10:0] top, bot, c;
    top = {1'b0, y};
    bot = top + {5'd0, span_px(sz)};
    c   = {2'b00, cl};
    return (top <= c) && (c < bot);
  endfunction

  function automatic logic [ADDR_W-1:0] byte_addr(input logic [6:0] base,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic [1:0] sel);
    return {base, 9'd0} + ({{(ADDR_W-IDX_W){1'b0}}, idx} << 3)
           + {{(ADDR_W-2){1'b0}}, sel};
  endfunction

endpackage

// File: rtl/sls_hit_test.sv
module sls_hit_test
  import sls_pkg::*;
(
  input  logic [1:0]     y_hi,
  input  logic [7:0]     y_lo,
  input  logic [7:0]     size_b,
  input  logic [8:0]     cmp,
  output logic           hit,
  output logic [Y_W-1:0] y_adj
);
  logic [Y_W-1:0] y_full;
  assign y_full = {y_hi, y_lo};
  assign hit    = covers(y_full, size_b, cmp);
  assign y_adj  = y_full - 10'd128;
endmodule

// File: rtl/sls_slot_list.sv
module sls_slot_list
  import sls_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wptr,
  input  slot_t            wdata,
  input  logic [PTR_W-1:0] rd_sel,
  output slot_t            rdata
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  slot_t cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (we && (wptr == PTR_W'(g)))
        cells[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_sel <= LAST) rdata = cells[rd_sel];
  end

  // R4: no write past the list
  assert_wptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wptr <= LAST));
endmodule

// File: rtl/sls_walker.sv
module sls_walker
  import sls_pkg::*;
#(
  parameter int WIDE_SLOTS   = 20,
  parameter int NARROW_SLOTS = 16,
  parameter int WIDE_LIMIT   = 80,
  parameter int NARROW_LIMIT = 64,
  parameter int CNT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [7:0]        line,
  input  logic [6:0]        base,
  output logic [ADDR_W-1:0] vram_addr,
  output logic              vram_rd,
  input  logic [7:0]        vram_data,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              slot_we,
  output logic [CNT_W-1:0]  slot_ptr,
  output slot_t             slot_data
);
  localparam logic [CNT_W-1:0] WIDE_INIT   = CNT_W'(WIDE_SLOTS);
  localparam logic [CNT_W-1:0] NARROW_INIT = CNT_W'(NARROW_SLOTS);
  localparam logic [7:0]       WIDE_LIM    = 8'(WIDE_LIMIT);
  localparam logic [7:0]       NARROW_LIM  = 8'(NARROW_LIMIT);

  scan_st_t         state;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sel, sel_q;
  logic             rd_q;
  logic [1:0]       b0;
  logic [7:0]       b1, b2;
  logic [IDX_W-1:0] b3;
  logic [7:0]       line_l;
  logic [6:0]       base_l;
  logic             wide_l;
  logic [7:0]       lim;
  logic             hit;
  logic [Y_W-1:0]   y_adj;
  logic             link_end, link_over;

  assign lim       = wide_l ? WIDE_LIM : NARROW_LIM;
  assign busy      = (state != ST_IDLE);
  assign vram_rd   = (state == ST_FETCH);
  assign vram_addr = byte_addr(base_l, idx, sel);
  assign link_end  = (b3 == '0) || (free_cnt == '0);
  assign link_over = ({1'b0, b3} >= lim);

  sls_hit_test u_hit (
    .y_hi  (b0),
    .y_lo  (b1),
    .size_b(b2),
    .cmp   (cmp_line(line_l)),
    .hit   (hit),
    .y_adj (y_adj)
  );

  assign slot_we   = (state == ST_COMPARE) && hit;
  assign slot_ptr  = free_cnt - CNT_W'(1);
  assign slot_data = '{size: b2, idx: idx, y: y_adj};

  // capture of read data, one cycle behind the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      sel_q <= '0;
      b0    <= '0;
      b1    <= '0;
      b2    <= '0;
      b3    <= '0;
    end else begin
      rd_q  <= vram_rd;
      sel_q <= sel;
      if (rd_q) begin
        case (sel_q)
          2'd0:    b0 <= vram_data[1:0];
          2'd1:    b1 <= vram_data;
          2'd2:    b2 <= vram_data;
          default: b3 <= vram_data[IDX_W-1:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      sel      <= '0;
      free_cnt <= '0;
      done     <= 1'b0;
      line_l   <= '0;
      base_l   <= '0;
      wide_l   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          line_l   <= line;
          base_l   <= base;
          wide_l   <= wide;
          idx      <= '0;
          sel      <= '0;
          free_cnt <= wide ? WIDE_INIT : NARROW_INIT;
          done     <= 1'b0;
          state    <= ST_FETCH;
        end
        ST_FETCH: begin
          sel <= sel + 2'd1;
          if (sel == 2'd3) state <= ST_COMPARE;
        end
        ST_COMPARE: begin
          if (hit) free_cnt <= free_cnt - CNT_W'(1);
          state <= ST_LINK;
        end
        default: begin
          if (link_end || link_over) begin
            if (link_over) idx <= '0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            idx   <= b3;
            state <= ST_FETCH;
          end
        end
      endcase
    end
  end

  assert_rd_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> busy);
  assert_entry_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> (vram_addr[2] == 1'b0));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_we |-> (free_cnt != '0));
  assert_index_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> ({1'b0, idx} < lim));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_free_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (free_cnt <= $past(free_cnt)));
endmodule

// File: rtl/sls_line_scanner.sv
module sls_line_scanner
  import sls_pkg::*;
#(
  parameter int WIDE_SLOTS   = 20,
  parameter int NARROW_SLOTS = 16,
  parameter int WIDE_LIMIT   = 80,
  parameter int NARROW_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wide_i,
  input  logic [7:0]  line_i,
  input  logic [6:0]  tbl_base_i,
  output logic [15:0] vram_addr_o,
  output logic        vram_rd_o,
  input  logic [7:0]  vram_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [4:0]  free_slots_o,
  input  logic [4:0]  slot_sel_i,
  output logic [7:0]  slot_size_o,
  output logic [6:0]  slot_idx_o,
  output logic [9:0]  slot_y_o
);
  localparam int MAX_SLOTS = (WIDE_SLOTS > NARROW_SLOTS) ? WIDE_SLOTS : NARROW_SLOTS;
  localparam int CNT_W     = 5;

  logic             slot_we;
  logic [CNT_W-1:0] slot_ptr;
  slot_t            slot_wdata, slot_rdata;

  sls_walker #(
    .WIDE_SLOTS  (WIDE_SLOTS),
    .NARROW_SLOTS(NARROW_SLOTS),
    .WIDE_LIMIT  (WIDE_LIMIT),
    .NARROW_LIMIT(NARROW_LIMIT),
    .CNT_W       (CNT_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .wide     (wide_i),
    .line     (line_i),
    .base     (tbl_base_i),
    .vram_addr(vram_addr_o),
    .vram_rd  (vram_rd_o),
    .vram_data(vram_data_i),
    .busy     (busy_o),
    .done     (done_o),
    .free_cnt (free_slots_o),
    .slot_we  (slot_we),
    .slot_ptr (slot_ptr),
    .slot_data(slot_wdata)
  );

  sls_slot_list #(
    .DEPTH(MAX_SLOTS),
    .PTR_W(CNT_W)
  ) u_list (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (slot_we),
    .wptr  (slot_ptr),
    .wdata (slot_wdata),
    .rd_sel(slot_sel_i),
    .rdata (slot_rdata)
  );

  assign slot_size_o = slot_rdata.size;
  assign slot_idx_o  = slot_rdata.idx;
  assign slot_y_o    = slot_rdata.y;
endmodule

// File: tb/sim_sls_line_scanner.sv
`timescale 1ns/1ps
module sim_sls_line_scanner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start_i, wide_i;
  logic [7:0]  line_i;
  logic [6:0]  tbl_base_i;
  logic [15:0] vram_addr_o;
  logic        vram_rd_o;
  logic [7:0]  vram_data_i;
  logic        busy_o, done_o;
  logic [4:0]  free_slots_o, slot_sel_i;
  logic [7:0]  slot_size_o;
  logic [6:0]  slot_idx_o;
  logic [9:0]  slot_y_o;

  sls_line_scanner u0 (.*);

  int errors = 0;
  int checks = 0;
  int rd_count = 0;
  int cycles = 0;
  logic [7:0] vram [int];

  int exp_sz [20];
  int exp_ix [20];
  int exp_y  [20];
  int exp_free, exp_visits;

  function automatic int rdm(int a);
    int k;
    k = a & 16'hFFFF;
    return vram.exists(k) ? int'(vram[k]) : 0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (vram_rd_o) begin
      vram_data_i <= 8'(rdm(int'(vram_addr_o)));
      rd_count    <= rd_count + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void put_entry(int base, int idx, int y, int sz, int link);
    int a;
    a = base * 512 + idx * 8;
    vram[(a + 0) & 16'hFFFF] = 8'(((y >> 8) & 3) | 8'hA4);
    vram[(a + 1) & 16'hFFFF] = 8'(y & 255);
    vram[(a + 2) & 16'hFFFF] = 8'(sz);
    vram[(a + 3) & 16'hFFFF] = 8'(link | 128);
    vram[(a + 4) & 16'hFFFF] = 8'h5A;
  endfunction

  function automatic void model(int base, int line, bit wide);
    int lim, cnt, idx, cl, a, y, h, b2;
    lim = wide ? 80 : 64;
    cnt = wide ? 20 : 16;
    idx = 0;
    cl  = ((line + 1) % 256) + 128;
    exp_visits = 0;
    for (int step = 0; step < 1000; step++) begin
      if (step > 0) begin
        if (idx == 0 || cnt == 0) break;
        if (idx >= lim) break;
      end
      a  = base * 512 + idx * 8;
      y  = (rdm(a) % 4) * 256 + rdm(a + 1);
      b2 = rdm(a + 2);
      h  = ((b2 % 4) + 1) * 8;
      exp_visits++;
      if (y <= cl && cl < y + h) begin
        cnt--;
        exp_sz[cnt] = b2;
        exp_ix[cnt] = idx;
        exp_y[cnt]  = (y + 1024 - 128) % 1024;
      end
      idx = rdm(a + 3) % 128;
    end
    exp_free = cnt;
  endfunction

  task automatic wait_done(string tag);
    int n;
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done_o == 1'b1, "R8", {tag, " done raised"}, int'(done_o), 1);
  endtask

  task automatic verify(string tag, bit wide, int r0);
    int init;
    init = wide ? 20 : 16;
    check(rd_count - r0 == 4 * exp_visits, "R2", {tag, " byte reads"},
          rd_count - r0, 4 * exp_visits);
    check(int'(free_slots_o) == exp_free, "R6", {tag, " free slots"},
          int'(free_slots_o), exp_free);
    for (int s = exp_free; s < init; s++) begin
      slot_sel_i = 5'(s);
      #1;
      check(int'(slot_size_o) == exp_sz[s], "R4", {tag, " slot size"},
            int'(slot_size_o), exp_sz[s]);
      check(int'(slot_idx_o) == exp_ix[s], "R5", {tag, " slot index"},
            int'(slot_idx_o), exp_ix[s]);
      check(int'(slot_y_o) == exp_y[s], "R3", {tag, " slot y"},
            int'(slot_y_o), exp_y[s]);
    end
  endtask

  task automatic do_scan(string tag, int base, int line, bit wide);
    int r0;
    model(base, line, wide);
    @(negedge clk);
    r0 = rd_count;
    tbl_base_i = 7'(base);
    line_i     = 8'(line);
    wide_i     = wide;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !done_o, "R8", {tag, " busy after start"},
          int'({busy_o, done_o}), 2);
    wait_done(tag);
    verify(tag, wide, r0);
  endtask

  always @(posedge clk) begin
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; wide_i = 1'b1; line_i = '0;
    tbl_base_i = '0; slot_sel_i = '0; vram_data_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !vram_rd_o, "R1", "idle after reset",
          int'({busy_o, done_o, vram_rd_o}), 0);
    check(free_slots_o == 5'd0, "R1", "free slots after reset", int'(free_slots_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5: short explicit chain with mixed hits
    vram.delete();
    put_entry(3, 0, 139, 8'h00, 5);
    put_entry(3, 5, 132, 8'h45, 2);
    put_entry(3, 2, 140, 8'h02, 9);
    put_entry(3, 9, 100, 8'h03, 7);
    put_entry(3, 7, 1023, 8'h03, 0);
    do_scan("chain", 3, 10, 1'b1);

    // R3 line 255 wraps to compare value 128; Y below 128 stored wrapped
    vram.delete();
    put_entry(9, 0, 120, 8'h01, 1);
    put_entry(9, 1, 128, 8'hF0, 2);
    put_entry(9, 2, 129, 8'h03, 0);
    do_scan("wrap", 9, 255, 1'b0);

    // R5 link 0 from entry 0 ends after one entry
    vram.delete();
    put_entry(1, 0, 300, 8'h00, 0);
    put_entry(1, 1, 300, 8'h00, 0);
    do_scan("link0", 1, 171, 1'b1);

    // R6 slot exhaustion, both modes
    vram.delete();
    for (int i = 0; i < 25; i++) put_entry(20, i, 200, 8'h00, i + 1);
    put_entry(20, 25, 200, 8'h00, 0);
    do_scan("fill_wide", 20, 71, 1'b1);
    do_scan("fill_narrow", 20, 71, 1'b0);

    // R7 per-frame index limit
    vram.delete();
    put_entry(40, 0, 150, 8'h02, 70);
    put_entry(40, 70, 150, 8'h01, 0);
    do_scan("limit_narrow", 40, 30, 1'b0);
    do_scan("limit_wide", 40, 30, 1'b1);

    // R2 address wrap at top of memory
    vram.delete();
    put_entry(127, 0, 200, 8'h03, 100);
    put_entry(127, 100, 190, 8'h03, 0);
    do_scan("base_wrap", 127, 71, 1'b1);

    // R8 start while busy is ignored
    vram.delete();
    for (int i = 0; i < 12; i++) put_entry(5, i, 130 + i * 4, 8'(i % 4), i + 1);
    put_entry(5, 12, 130, 8'h00, 0);
    begin
      int r0;
      model(5, 10, 1'b1);
      @(negedge clk);
      r0 = rd_count;
      tbl_base_i = 7'd5; line_i = 8'd10; wide_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      line_i = 8'd60; wide_i = 1'b0; tbl_base_i = 7'd6; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done("restart");
      verify("restart", 1'b1, r0);
    end

    // R9 R3 sweep of lines over an ascending chain, both modes
    vram.delete();
    for (int i = 0; i < 30; i++)
      put_entry(64, i, 100 + i * 9, ((i * 37) & 8'hFC) | (i % 4), (i + 1) % 30);
    for (int ln = 0; ln < 256; ln += 5)
      do_scan("sweep", 64, ln, ln[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule